// File: doc/BRIEF.md
# Day-Hour-Minute-Second Real-Time Clock

This block is a real-time clock peripheral on a simple single-cycle 32-bit register bus. It keeps time as one packed word holding a 15-bit day count, hours, minutes and seconds. The time base is a slow clock input whose rising edges mark half-seconds. These edges are brought into the bus clock domain through a synchronizer and an edge detector. Two half-second steps make one second. The counter only runs while the control enable bit is set. Software normally loads a time value first and then sets the enable bit.

An alarm register is compared against the time of day only, meaning hours, minutes and seconds. A match sets a sticky alarm flag. That flag drives an interrupt output and a wakeup output, each gated by its own control bit. Five more sticky flags record half-second steps and second, minute, hour and day rollovers. Their OR, masked by matching enable bits, drives a periodic interrupt. Software clears any flag by writing a one to it.

A write-completion status bit models the latency of handing register updates to the slow domain. A two-state machine owns this bit:
- `SY_READY`: the bit reads one.
- Transition `write_seen`: any register write moves the machine to `SY_PENDING`.
- `SY_PENDING`: the machine counts slow-clock edges. A write arriving here takes transition `write_restart`, which zeroes the count.
- Transition `sync_complete`: after `SYNC_EDGES` edges with no write, the machine returns to `SY_READY`.

Writes are never refused, and they take effect in the order they arrive.

Top module: `rtc_dhms`

## Requirements
- R1: After reset, control and counter read 0, status reads 0x0001_0000 (write done set, no flags), and `alarm_irq`, `wake_req` and `tick_irq` are low.
- R2: A read at byte offset 0x00 returns 0x030110 in bits 31:8 and the parameter `REV` in bits 7:0. Unmapped offsets read 0.
- R3: The counter (0x10), alarm (0x14), control (0x18, bits 7:0) and trim (0x20) registers read back what was written. Time words pack seconds in 5:0, minutes in 11:6, hours in 16:12 and day in 31:17.
- R4: The counter advances only while control bit 0 is set. It advances by one second for every two rising edges of `slow_clk`, and a counter write restarts the half-second phase.
- R5: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. An hour wrap increments the day field, which wraps from 0x7FFF to 0.
- R6: Status bit 2 sets on the second step where the new hours, minutes and seconds equal the alarm's fields. The alarm's day field plays no part in the match.
- R7: `alarm_irq` equals status bit 2 AND control bit 2. `wake_req` equals status bit 2 AND control bit 1.
- R8: While running, status bits 7, 6, 5, 4 and 3 set on each half-second step, second step, minute wrap, hour wrap and day increment, respectively.
- R9: Writing status clears each flag in bits 7:2 whose written bit is one. Written zeros leave flags unchanged.
- R10: Status bit 16 reads 0 from the cycle after any write. It returns to 1 after `SYNC_EDGES` slow-clock rising edges with no further write, and a write while it is 0 restarts that count.
- R11: `tick_irq` is high exactly when some status bit in 7:3 and the same control bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Half-second time base, asynchronous to `clk` |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| alarm_irq | output | 1 | Alarm interrupt |
| wake_req | output | 1 | Wakeup request |
| tick_irq | output | 1 | Periodic interrupt |

## Verification
The bench builds the block with `SYNC_EDGES` = 3, `SYNC_STAGES` = 2 and `REV` = 0x01. With these values the write-done return arrives on the third slow edge, so a write placed after the second edge can show the restart. The short synchronizer lets each half-second step finish within a dozen bus cycles. This keeps runs that cross the 23:59:59 boundary and the day-field wrap at 0x7FFF to a handful of slow edges.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DAY_W = 15;
    localparam logic [23:0] ID_CODE = 24'h030110;

    localparam logic [7:0] OFS_ID   = 8'h00;
    localparam logic [7:0] OFS_CNT  = 8'h10;
    localparam logic [7:0] OFS_ALM  = 8'h14;
    localparam logic [7:0] OFS_CTL  = 8'h18;
    localparam logic [7:0] OFS_STA  = 8'h1C;
    localparam logic [7:0] OFS_TRIM = 8'h20;

    localparam int CB_RUN   = 0;
    localparam int CB_WAKE  = 1;
    localparam int CB_ALARM = 2;
    localparam int CB_DAY   = 3;
    localparam int CB_HOUR  = 4;
    localparam int CB_MIN   = 5;
    localparam int CB_SEC   = 6;
    localparam int CB_HALF  = 7;
    localparam int SB_DONE  = 16;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [4:0]       hr;
        logic [5:0]       mn;
        logic [5:0]       sc;
    } rtc_time_t;

    typedef enum logic [0:0] {
        SY_READY   = 1'b0,
        SY_PENDING = 1'b1
    } sync_state_t;
endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
            prev_q  <= chain_q[LAST];
        end
    end

    assign rise_pulse = chain_q[LAST] & ~prev_q;
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step_half,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t cnt_q,
    output rtc_time_t cnt_nxt,
    output logic      ev_half,
    output logic      ev_sec,
    output logic      ev_min,
    output logic      ev_hour,
    output logic      ev_day
);
    logic phase_q;
    logic sc_wrap, mn_wrap, hr_wrap;

    always_comb begin
        sc_wrap = (cnt_q.sc >= 6'd59);
        mn_wrap = (cnt_q.mn >= 6'd59);
        hr_wrap = (cnt_q.hr >= 5'd23);
        ev_half = step_half;
        ev_sec  = step_half & phase_q;
        ev_min  = ev_sec & sc_wrap;
        ev_hour = ev_min & mn_wrap;
        ev_day  = ev_hour & hr_wrap;

        cnt_nxt = cnt_q;
        if (ev_sec)  cnt_nxt.sc  = sc_wrap ? 6'd0 : cnt_q.sc + 6'd1;
        if (ev_min)  cnt_nxt.mn  = mn_wrap ? 6'd0 : cnt_q.mn + 6'd1;
        if (ev_hour) cnt_nxt.hr  = hr_wrap ? 5'd0 : cnt_q.hr + 5'd1;
        if (ev_day)  cnt_nxt.day = cnt_q.day + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= load_val;
            phase_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            if (step_half) phase_q <= ~phase_q;
        end
    end
endmodule

// File: rtl/rtc_wsync.sv
module rtc_wsync
    import rtc_pkg::*;
#(
    parameter int SYNC_EDGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_any,
    input  logic slow_edge,
    output logic wr_done
);
    localparam int CW = $clog2(SYNC_EDGES + 1);
    localparam logic [CW-1:0] LAST_EDGE = CW'(SYNC_EDGES - 1);

    sync_state_t state_q, state_d;
    logic [CW-1:0] edges_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SY_READY:   if (wr_any) state_d = SY_PENDING;
            SY_PENDING: if (!wr_any && slow_edge && edges_q == LAST_EDGE)
                            state_d = SY_READY;
            default:    state_d = SY_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SY_READY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                edges_q <= '0;
        else if (wr_any)           edges_q <= '0;
        else if (state_q == SY_PENDING && slow_edge)
                                   edges_q <= edges_q + 1'b1;
    end

    always_comb begin
        unique case (state_q)
            SY_READY:   wr_done = 1'b1;
            SY_PENDING: wr_done = 1'b0;
            default:    wr_done = 1'b1;
        endcase
    end
endmodule

// File: rtl/rtc_dhms.sv
module rtc_dhms
    import rtc_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int          SYNC_EDGES  = 3,
    parameter logic [7:0]  REV         = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              alarm_irq,
    output logic              wake_req,
    output logic              tick_irq
);
    localparam int FLAG_LO = CB_ALARM;
    localparam int FLAG_HI = CB_HALF;

    logic [7:0]  ofs;
    logic        wr_any, wr_cnt, wr_alm, wr_ctl, wr_sta, wr_trim;
    logic        hs_pulse, step_half, wr_done;
    logic [7:0]  ctrl_q;
    logic [7:0]  flag_q;
    rtc_time_t   alm_q, cnt_q, cnt_nxt;
    logic [31:0] trim_q;
    logic        ev_half, ev_sec, ev_min, ev_hour, ev_day, alarm_hit;
    logic [7:0]  flag_set;

    assign ofs     = 8'(bus_addr);
    assign wr_any  = bus_sel & bus_wr;
    assign wr_cnt  = wr_any & (ofs == OFS_CNT);
    assign wr_alm  = wr_any & (ofs == OFS_ALM);
    assign wr_ctl  = wr_any & (ofs == OFS_CTL);
    assign wr_sta  = wr_any & (ofs == OFS_STA);
    assign wr_trim = wr_any & (ofs == OFS_TRIM);

    rtc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .async_in(slow_clk), .rise_pulse(hs_pulse)
    );

    assign step_half = hs_pulse & ctrl_q[CB_RUN];

    rtc_time_core u_core (
        .clk(clk), .rst_n(rst_n), .step_half(step_half),
        .load(wr_cnt), .load_val(rtc_time_t'(bus_wdata)),
        .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
        .ev_half(ev_half), .ev_sec(ev_sec), .ev_min(ev_min),
        .ev_hour(ev_hour), .ev_day(ev_day)
    );

    rtc_wsync #(.SYNC_EDGES(SYNC_EDGES)) u_wsync (
        .clk(clk), .rst_n(rst_n), .wr_any(wr_any),
        .slow_edge(hs_pulse), .wr_done(wr_done)
    );

    assign alarm_hit = ev_sec & (cnt_nxt.hr == alm_q.hr) &
                       (cnt_nxt.mn == alm_q.mn) & (cnt_nxt.sc == alm_q.sc);

    always_comb begin
        flag_set           = '0;
        flag_set[CB_ALARM] = alarm_hit;
        flag_set[CB_DAY]   = ev_day;
        flag_set[CB_HOUR]  = ev_hour;
        flag_set[CB_MIN]   = ev_min;
        flag_set[CB_SEC]   = ev_sec;
        flag_set[CB_HALF]  = ev_half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            alm_q  <= '0;
            trim_q <= '0;
        end else begin
            if (wr_ctl)  ctrl_q <= bus_wdata[7:0];
            if (wr_alm)  alm_q  <= rtc_time_t'(bus_wdata);
            if (wr_trim) trim_q <= bus_wdata;
        end
    end

    for (genvar i = 0; i < 8; i++) begin : g_flag
        if (i >= FLAG_LO && i <= FLAG_HI) begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           flag_q[i] <= 1'b0;
                else if (flag_set[i]) flag_q[i] <= 1'b1;
                else if (wr_sta && bus_wdata[i]) flag_q[i] <= 1'b0;
            end
        end else begin : g_tie
            assign flag_q[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_ID:   bus_rdata = {ID_CODE, REV};
            OFS_CNT:  bus_rdata = cnt_q;
            OFS_ALM:  bus_rdata = alm_q;
            OFS_CTL:  bus_rdata = {24'd0, ctrl_q};
            OFS_STA:  bus_rdata = {15'd0, wr_done, 8'd0, flag_q};
            OFS_TRIM: bus_rdata = trim_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign alarm_irq = flag_q[CB_ALARM] & ctrl_q[CB_ALARM];
    assign wake_req  = flag_q[CB_ALARM] & ctrl_q[CB_WAKE];
    assign tick_irq  = |(flag_q[FLAG_HI:CB_DAY] & ctrl_q[FLAG_HI:CB_DAY]);
endmodule

// File: rtl/rtc_dhms_chk.sv
module rtc_dhms_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_any,
    input logic        wr_done,
    input logic        hs_pulse,
    input logic [31:0] cnt,
    input logic [7:0]  ctrl,
    input logic        alarm_irq,
    input logic        wake_req
);
    p_write_drops_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |=> !wr_done);

    p_done_needs_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_done) && wr_done) |-> $past(hs_pulse));

    p_frozen_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[0] && !wr_any) |=> $stable(cnt));

    p_sec_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> ($stable(cnt) || cnt[5:0] == 6'($past(cnt[5:0]) + 6'd1) || cnt[5:0] == 6'd0));

    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> ctrl[2]);

    p_wake_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ctrl[1]);
endmodule

bind rtc_dhms rtc_dhms_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_any(wr_any), .wr_done(wr_done),
    .hs_pulse(hs_pulse), .cnt(cnt_q), .ctrl(ctrl_q),
    .alarm_irq(alarm_irq), .wake_req(wake_req)
);

// File: tb/test_rtc_dhms.sv
module test_rtc_dhms;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alarm_irq, wake_req, tick_irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rtc_dhms #(.ADDR_W(8), .SYNC_STAGES(2), .SYNC_EDGES(3), .REV(8'h01)) i_rtc_dhms (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .alarm_irq(alarm_irq), .wake_req(wake_req),
        .tick_irq(tick_irq)
    );

    function automatic logic [31:0] tword(int d, int h, int m, int s);
        return {15'(d), 5'(h), 6'(m), 6'(s)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic half_tick();
        @(negedge clk); slow_clk = 1'b1;
        repeat (6) @(negedge clk);
        slow_clk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h18, v); check("R1 ctrl", v, 32'h0);
        rd(8'h10, v); check("R1 count", v, 32'h0);
        rd(8'h1C, v); check("R1 status", v, 32'h0001_0000);
        check("R1 outputs", {29'd0, alarm_irq, wake_req, tick_irq}, 32'h0);
    endtask

    task automatic t_id_regs();
        logic [31:0] v;
        rd(8'h00, v); check("R2 id", v, 32'h0301_1001);
        rd(8'h0C, v); check("R2 unmapped", v, 32'h0);
        wr(8'h20, 32'hA5C3_0F1E); rd(8'h20, v); check("R3 trim", v, 32'hA5C3_0F1E);
        wr(8'h14, tword(3, 4, 5, 6)); rd(8'h14, v); check("R3 alarm", v, tword(3, 4, 5, 6));
        wr(8'h10, tword(100, 12, 34, 56)); rd(8'h10, v); check("R3 count", v, tword(100, 12, 34, 56));
        wr(8'h18, 32'h0000_00F0); rd(8'h18, v); check("R3 ctrl", v, 32'hF0);
    endtask

    task automatic t_write_done();
        logic [31:0] v;
        wr(8'h18, 32'h0);
        repeat (3) half_tick();
        rd(8'h1C, v); check("R10 settled", v[16], 1'b1);
        wr(8'h20, 32'h1);
        rd(8'h1C, v); check("R10 drop", v[16], 1'b0);
        half_tick(); half_tick();
        rd(8'h1C, v); check("R10 still pending", v[16], 1'b0);
        wr(8'h20, 32'h2);
        half_tick(); half_tick();
        rd(8'h1C, v); check("R10 restart", v[16], 1'b0);
        half_tick();
        rd(8'h1C, v); check("R10 return", v[16], 1'b1);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'hFC);
        wr(8'h10, tword(1, 2, 3, 4));
        repeat (4) half_tick();
        rd(8'h10, v); check("R4 frozen", v, tword(1, 2, 3, 4));
        rd(8'h1C, v); check("R4 no flags", {24'd0, v[7:0]}, 32'h0);
    endtask

    task automatic t_running();
        logic [31:0] v;
        wr(8'h10, tword(1, 2, 3, 4));
        wr(8'h18, 32'h1);
        half_tick();
        rd(8'h10, v); check("R4 half no step", v, tword(1, 2, 3, 4));
        half_tick();
        rd(8'h10, v); check("R4 one second", v, tword(1, 2, 3, 5));
        wr(8'h18, 32'h0);
    endtask

    task automatic t_rollover();
        logic [31:0] v;
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'hFC);
        wr(8'h10, tword(5, 23, 59, 59));
        wr(8'h18, 32'h1);
        half_tick();
        rd(8'h1C, v); check("R8 half flag only", {24'd0, v[7:0]}, 32'h80);
        half_tick();
        rd(8'h10, v); check("R5 day carry", v, tword(6, 0, 0, 0));
        rd(8'h1C, v); check("R8 all rollover flags", {24'd0, v[7:0]}, 32'hF8);
        wr(8'h18, 32'h0);
        wr(8'h10, tword(32767, 23, 59, 59));
        wr(8'h18, 32'h1);
        half_tick(); half_tick();
        rd(8'h10, v); check("R5 day wrap", v, tword(0, 0, 0, 0));
        wr(8'h18, 32'h0);
        wr(8'h10, tword(2, 7, 30, 59));
        wr(8'h1C, 32'hFC);
        wr(8'h18, 32'h1);
        half_tick(); half_tick();
        rd(8'h10, v); check("R5 minute carry", v, tword(2, 7, 31, 0));
        rd(8'h1C, v); check("R8 minute flags", {24'd0, v[7:0]}, 32'hE0);
        wr(8'h18, 32'h0);
    endtask

    task automatic t_alarm();
        logic [31:0] v;
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'hFC);
        wr(8'h14, tword(77, 1, 2, 4));
        wr(8'h10, tword(9, 1, 2, 3));
        wr(8'h18, 32'h7);
        half_tick();
        rd(8'h1C, v); check("R6 no early match", v[2], 1'b0);
        half_tick();
        rd(8'h1C, v); check("R6 match ignores day", v[2], 1'b1);
        check("R7 irq and wake", {30'd0, alarm_irq, wake_req}, 32'h3);
        wr(8'h18, 32'h0);
        #1 check("R7 gated off", {30'd0, alarm_irq, wake_req}, 32'h0);
        wr(8'h18, 32'h2);
        #1 check("R7 wake only", {30'd0, alarm_irq, wake_req}, 32'h1);
        wr(8'h1C, 32'h0);
        rd(8'h1C, v); check("R9 zero write keeps", v[2], 1'b1);
        wr(8'h1C, 32'h4);
        rd(8'h1C, v); check("R9 one clears", v[2], 1'b0);
        wr(8'h18, 32'h0);
    endtask

    task automatic t_tick_irq();
        logic [31:0] v;
        wr(8'h1C, 32'hFC);
        wr(8'h10, tword(0, 0, 0, 0));
        wr(8'h18, 32'h41);
        half_tick();
        #1 check("R11 half flag not enabled", {31'd0, tick_irq}, 32'h0);
        wr(8'h18, 32'h81);
        #1 check("R11 half enabled", {31'd0, tick_irq}, 32'h1);
        wr(8'h1C, 32'h80);
        rd(8'h1C, v); check("R9 clear half", v[7], 1'b0);
        check("R11 low after clear", {31'd0, tick_irq}, 32'h0);
        wr(8'h18, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_id_regs();
        t_write_done();
        t_disabled();
        t_running();
        t_rollover();
        t_alarm();
        t_tick_irq();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule